// File: doc/BRIEF.md
# Row Address Sequencer for a Multiplexed Sensor Array

This block produces the row-select bias enables for a sensor array that is read out by time-division multiplexing. A counter running on the master clock cuts time into row periods. At the start of each period the block takes the next row index from a programmable sequence table. That row's bias stays low for a programmable number of cycles and then goes high for a programmable number of cycles. Every other row is held at zero for the whole period. The rows can be visited in any order, and a programmable length sets the point where the sequence wraps back to its first entry.

Downstream readout channels see three outputs: a one-cycle strobe on the first clock of each row period, the current row index, and the one-hot enable vector. A small write/read register port sets the period, the delay, the width, the sequence length and the table entries. Every write lands in a shadow copy first. The shadow copy becomes active only when the sequence wraps, so no row period is ever cut short or stretched by a write.

Top module: `row_addr_seq`

## Requirements
- R1: At most one bit of `row_en` is high in any cycle. When a bit is high, it is bit `row_idx`.
- R2: Rows are visited in table order, table[0], table[1] up to table[len-1], and then the sequence starts again at table[0]. Table entry i sits at register address 32+i: address bit 5 set, bits 4:0 = i, value in data bits 4:0.
- R3: A row period lasts exactly `period` cycles. `row_start` is high only on its first cycle. `row_idx` changes only on a cycle where `row_start` is high.
- R4: Number the cycles of a row period from 0. The bias of the selected row is on exactly when delay <= k < delay+width. When delay+width = period-1, the last cycle of the period is off.
- R5: When delay+width is larger than period-1, the pulse ends with the last cycle of the row period and never reaches into the next row.
- R6: A write to period, delay, width, length or a table entry leaves the pass that is running unchanged. It takes effect from the first row of the next pass.
- R7: Register addresses: 0 = period, 1 = delay, 2 = width, 3 = sequence length, 32..63 = table. Reads return the last value written, after clamping, zero-extended to 16 bits. Any other address reads zero.
- R8: A length write of 0 is stored as 1, and a length above 32 is stored as 32. A period write below 2 is stored as 2. Timing values that do not fit in 12 bits saturate at 4095.
- R9: After reset the period is 8, the delay 2, the width 5, the length 32 and the table is identity (entry i = i). The first cycle after reset is the row start of row 0, with the bias off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address for write and read |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Shadow value at `cfg_addr` (combinational) |
| row_en | output | N_ROWS (32) | One-hot row bias enables |
| row_idx | output | 5 | Row selected in the current period |
| row_start | output | 1 | High on the first cycle of every row period |

## Verification
The default identity table at the reset timing shows whether plain ascending order and the delay/width window with a dead last cycle come out right. A five-entry table that is not in ascending order, including row 31 and row 0, separates sequencing driven by the table from a simple rotation. It also exercises a sequence that wraps before the table's end. A setting whose window overruns the row period catches a pulse that leaks into the next row. A zero delay with length written as 0 tests the clamp to one row and a bias that is on from the strobe cycle. Every new setting is written in the middle of the pass before the one it is meant for, so a design that applies writes at once fails the period and row checks of the pass that is still running.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
    localparam int unsigned CNT_W     = 12;
    localparam int unsigned IDX_W     = 5;
    localparam int unsigned SEQ_DEPTH = 32;
    localparam int unsigned PTR_W     = $clog2(SEQ_DEPTH);
    localparam int unsigned LEN_W     = $clog2(SEQ_DEPTH + 1);
    localparam int unsigned ADDR_W    = PTR_W + 1;
    localparam int unsigned DATA_W    = 16;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        cnt_t period;
        cnt_t delay;
        cnt_t width;
        len_t len;
    } timing_t;

    typedef idx_t [SEQ_DEPTH-1:0] seq_tab_t;
endpackage

// File: rtl/rowseq_cfg.sv
module rowseq_cfg
    import rowseq_pkg::*;
#(
    parameter cnt_t RST_PERIOD = cnt_t'(8),
    parameter cnt_t RST_DELAY  = cnt_t'(2),
    parameter cnt_t RST_WIDTH  = cnt_t'(5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output timing_t           act_tim,
    output seq_tab_t          act_tab,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        timing_t  shd_tim;
        seq_tab_t shd_tab;
        timing_t  act_tim;
        seq_tab_t act_tab;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    function automatic cfg_st_t rst_val();
        cfg_st_t r;
        r.shd_tim.period = RST_PERIOD;
        r.shd_tim.delay  = RST_DELAY;
        r.shd_tim.width  = RST_WIDTH;
        r.shd_tim.len    = len_t'(SEQ_DEPTH);
        for (int i = 0; i < SEQ_DEPTH; i++) begin
            r.shd_tab[i] = idx_t'(i);
        end
        r.act_tim = r.shd_tim;
        r.act_tab = r.shd_tab;
        return r;
    endfunction

    function automatic cnt_t sat_cnt(logic [DATA_W-1:0] v);
        if (v > DATA_W'({CNT_W{1'b1}})) return '1;
        return v[CNT_W-1:0];
    endfunction

    function automatic cnt_t sat_period(logic [DATA_W-1:0] v);
        cnt_t c;
        c = sat_cnt(v);
        if (c < cnt_t'(2)) c = cnt_t'(2);
        return c;
    endfunction

    function automatic len_t clamp_len(logic [DATA_W-1:0] v);
        if (v == '0) return len_t'(1);
        if (v > DATA_W'(SEQ_DEPTH)) return len_t'(SEQ_DEPTH);
        return v[LEN_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr[ADDR_W-1]) begin
                st_d.shd_tab[addr[PTR_W-1:0]] = wdata[IDX_W-1:0];
            end else if (addr[ADDR_W-2:2] == '0) begin
                case (addr[1:0])
                    2'd0:    st_d.shd_tim.period = sat_period(wdata);
                    2'd1:    st_d.shd_tim.delay  = sat_cnt(wdata);
                    2'd2:    st_d.shd_tim.width  = sat_cnt(wdata);
                    default: st_d.shd_tim.len    = clamp_len(wdata);
                endcase
            end
        end
        if (commit) begin
            st_d.act_tim = st_q.shd_tim;
            st_d.act_tab = st_q.shd_tab;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_val();
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1]) begin
            rdata = DATA_W'(st_q.shd_tab[addr[PTR_W-1:0]]);
        end else if (addr[ADDR_W-2:2] == '0) begin
            case (addr[1:0])
                2'd0:    rdata = DATA_W'(st_q.shd_tim.period);
                2'd1:    rdata = DATA_W'(st_q.shd_tim.delay);
                2'd2:    rdata = DATA_W'(st_q.shd_tim.width);
                default: rdata = DATA_W'(st_q.shd_tim.len);
            endcase
        end
    end

    assign act_tim = st_q.act_tim;
    assign act_tab = st_q.act_tab;
endmodule

// File: rtl/rowseq_timer.sv
module rowseq_timer
    import rowseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t period,
    output cnt_t phase,
    output logic last
);
    typedef struct packed {
        cnt_t phase;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        last = (st_q.phase >= period - cnt_t'(1));
        if (last) st_d.phase = '0;
        else      st_d.phase = st_q.phase + cnt_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
endmodule

// File: rtl/rowseq_ptr.sv
module rowseq_ptr
    import rowseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  len_t len,
    output ptr_t ptr,
    output logic commit
);
    typedef struct packed {
        ptr_t ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = step && (len_t'(st_q.ptr) >= len - len_t'(1));
        if (commit)    st_d.ptr = '0;
        else if (step) st_d.ptr = st_q.ptr + ptr_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/rowseq_decode.sv
module rowseq_decode
    import rowseq_pkg::*;
#(
    parameter int unsigned N_ROWS = 32
) (
    input  logic              on,
    input  idx_t              idx,
    output logic [N_ROWS-1:0] en
);
    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        assign en[i] = on && (idx == idx_t'(i));
    end
endmodule

// File: rtl/row_addr_seq.sv
module row_addr_seq
    import rowseq_pkg::*;
#(
    parameter int unsigned N_ROWS     = 32,
    parameter cnt_t        RST_PERIOD = cnt_t'(8),
    parameter cnt_t        RST_DELAY  = cnt_t'(2),
    parameter cnt_t        RST_WIDTH  = cnt_t'(5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic [N_ROWS-1:0] row_en,
    output logic [4:0]        row_idx,
    output logic              row_start
);
    timing_t    act_tim;
    seq_tab_t   act_tab;
    cnt_t       phase;
    logic       last;
    ptr_t       ptr;
    logic       commit;
    logic       bias_on;
    logic [CNT_W:0] win_end;

    rowseq_cfg #(
        .RST_PERIOD (RST_PERIOD),
        .RST_DELAY  (RST_DELAY),
        .RST_WIDTH  (RST_WIDTH)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .commit  (commit),
        .act_tim (act_tim),
        .act_tab (act_tab),
        .rdata   (cfg_rdata)
    );

    rowseq_timer timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (act_tim.period),
        .phase  (phase),
        .last   (last)
    );

    rowseq_ptr ptr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (last),
        .len    (act_tim.len),
        .ptr    (ptr),
        .commit (commit)
    );

    always_comb begin
        win_end = {1'b0, act_tim.delay} + {1'b0, act_tim.width};
        bias_on = ({1'b0, phase} >= {1'b0, act_tim.delay}) && ({1'b0, phase} < win_end);
    end

    assign row_idx   = act_tab[ptr];
    assign row_start = (phase == '0);

    rowseq_decode #(.N_ROWS(N_ROWS)) dec_i (
        .on  (bias_on),
        .idx (act_tab[ptr]),
        .en  (row_en)
    );
endmodule

// File: rtl/row_addr_seq_chk.sv
module row_addr_seq_chk
    import rowseq_pkg::*;
#(
    parameter int unsigned N_ROWS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_ROWS-1:0] row_en,
    input logic [4:0]        row_idx,
    input logic              row_start,
    input logic              commit,
    input timing_t           act_tim,
    input logic [5:0]        cfg_addr,
    input logic [15:0]       cfg_rdata
);
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en));

    p_en_matches_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en != '0) |-> row_en[row_idx]);

    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !row_start |-> $stable(row_idx));

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> !row_start);

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_tim));

    p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd3) |-> (cfg_rdata >= 16'd1 && cfg_rdata <= 16'(SEQ_DEPTH)));
endmodule

bind row_addr_seq row_addr_seq_chk #(.N_ROWS(N_ROWS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_en    (row_en),
    .row_idx   (row_idx),
    .row_start (row_start),
    .commit    (commit),
    .act_tim   (act_tim),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/row_addr_seq_tb_top.sv
module row_addr_seq_tb_top;
    localparam int N_ROWS = 32;

    typedef struct {
        int row;
        int p;
        int d;
        int w;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [5:0]        cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic [15:0]       cfg_rdata;
    logic [N_ROWS-1:0] row_en;
    logic [4:0]        row_idx;
    logic              row_start;

    int    n_checks = 0;
    int    n_fail = 0;
    int    seen = 0;
    bit    mon_on = 0;
    bit    mon_done = 0;
    bit    finished = 0;
    item_t exp_q[$];
    int    tab_b[5] = '{7, 3, 31, 0, 12};

    always #4 clk = ~clk;

    row_addr_seq #(.N_ROWS(N_ROWS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .row_en    (row_en),
        .row_idx   (row_idx),
        .row_start (row_start)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_pass(int len, int p, int d, int w, bit use_b);
        for (int i = 0; i < len; i++) begin
            item_t it;
            it.row = use_b ? tab_b[i] : i;
            it.p = p;
            it.d = d;
            it.w = w;
            exp_q.push_back(it);
        end
    endtask

    task automatic wr(int a, int v);
        cfg_we = 1'b1;
        cfg_addr = 6'(a);
        cfg_wdata = 16'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(int a, int exp, string req);
        cfg_addr = 6'(a);
        #1;
        check(cfg_rdata == 16'(exp), req, cfg_rdata, exp);
    endtask

    // Monitor: pops one expected row per row start and checks every cycle of it
    item_t cur;
    bit    have_cur = 0;
    int    k = 0;
    always @(negedge clk) begin
        if (mon_on && !mon_done) begin
            if (row_start) begin
                if (have_cur) check(k + 1 == cur.p, "R3 R6 period length", k + 1, cur.p);
                k = 0;
                if (exp_q.size() == 0) begin
                    have_cur = 0;
                    mon_done = 1;
                end else begin
                    cur = exp_q.pop_front();
                    have_cur = 1;
                    seen++;
                    check(row_idx == 5'(cur.row), "R2 R6 row order", row_idx, cur.row);
                end
            end else begin
                k++;
            end
            if (have_cur && !mon_done) begin
                logic [N_ROWS-1:0] e;
                bit on;
                on = (k >= cur.d) && (k < cur.d + cur.w);
                e = on ? (N_ROWS'(1) << cur.row) : '0;
                if (cur.d + cur.w > cur.p - 1)
                    check(row_en == e, "R5 pulse cut at period end", row_en, e);
                else
                    check(row_en == e, "R4 R1 bias window", row_en, e);
                check(k < cur.p, "R3 no late row start", k, cur.p);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(row_en == '0, "R9 bias off in reset", row_en, 0);
        rd_chk(0, 8, "R9 reset period");
        rd_chk(1, 2, "R9 reset delay");
        rd_chk(3, 32, "R9 reset length");
        rd_chk(33, 1, "R9 reset table identity");

        push_pass(32, 8, 2, 5, 0);
        push_pass(5, 6, 1, 4, 1);
        push_pass(5, 6, 1, 4, 1);
        push_pass(3, 5, 3, 6, 1);
        for (int i = 0; i < 3; i++) push_pass(1, 4, 0, 3, 1);

        @(posedge clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1;

        // pass B written during pass A (R6)
        wait (seen >= 1);
        @(negedge clk);
        for (int i = 0; i < 5; i++) wr(32 + i, tab_b[i]);
        wr(0, 6);
        wr(1, 1);
        wr(2, 4);
        wr(3, 5);
        rd_chk(0, 6, "R7 period readback");
        rd_chk(34, 31, "R7 table readback");
        rd_chk(12, 0, "R7 unmapped reads zero");

        // pass C (overrun window) written during second pass B
        wait (seen >= 38);
        @(negedge clk);
        wr(0, 5);
        wr(1, 3);
        wr(2, 6);
        wr(3, 3);

        // pass D written during pass C; length 0 clamps to 1
        wait (seen >= 43);
        @(negedge clk);
        wr(0, 4);
        wr(1, 0);
        wr(2, 3);
        wr(3, 0);
        rd_chk(3, 1, "R8 length zero clamps to one");

        wait (mon_done);
        check(seen == 48, "R2 all expected rows seen", seen, 48);
        finished = 1;
        summary();
        $finish;
    end
endmodule